// File: doc/BRIEF.md
# Peripheral Channel Register Endpoint

This block is the device-facing end of one I/O channel. A host reaches it over a 12-bit bidirectional word path. The path is modelled as three ports: a word in, a word out and an output enable. It also uses two active-low strobes (RD, WR) and a register-select line. Two registers are reachable:
- With select at 0, the host reaches the device's data register.
- With select at 1, the host reaches its command/status register. A read returns the device's live status word. A write stores a command word and raises a one-clock command pulse toward the device logic.

A device whose native word is narrower than 12 bits keeps its value in the low bits. The upper bits it presents on the bus are always zero.

The block also holds the two handshakes the channel offers.
- **Interrupt.** A one-clock request from the device logic pulls the active-low interrupt line down. The line stays down until the host's active-low acknowledge is seen.
- **Transfer stretch.** A slow device can stretch every transfer. The active-low wait line drops in the very cycle a strobe is first seen. It stays down until the device logic reports ready. Only then is the transfer committed: the write is latched, or the read counts as taken.

The operator's online switch is passed to the host as a registered online flag.

Top module: `chan_endpoint`

## Requirements
- R1: Reset (`bus_rst` high) clears the data register, the command register, any pending interrupt and the online flag. After reset: `int_n`=1, `wait_n`=1, `dq_oe`=0, and both pulses are 0.
- R2: While `rd_n` is 0, `dq_oe` is 1 and `dq_out` shows the selected source in the same cycle. With `sel`=0 that source is the data register; with `sel`=1 it is `dev_status`.
- R3: While `rd_n` is 1, `dq_oe` is 0 and `dq_out` is all zeros.
- R4: `dq_out` bits [11:NAT_W] are always 0; native values sit in bits [NAT_W-1:0].
- R5: A committed write with `sel`=0 stores `dq_in[NAT_W-1:0]` in the data register. `dev_data` shows it one clock after the commit edge; the upper input bits are dropped.
- R6: A committed write with `sel`=1 stores `dq_in[NAT_W-1:0]` in the command register (`dev_cmd`) and raises `cmd_pulse` for exactly one clock, one clock after the commit edge.
- R7: A committed read with `sel`=0 raises `data_taken` for one clock, one clock after the commit edge. A read with `sel`=1 never raises it.
- R8: A `dev_req` pulse drives `int_n` to 0 from the next clock. `int_n` stays 0 until `ack_n` is sampled at 0, then returns to 1 the clock after. If `dev_req` and `ack_n`=0 are sampled together, the acknowledge wins and `int_n` stays 1.
- R9: With STRETCH=1, `wait_n` is 0 in the cycle a strobe is first seen. It stays 0 while `dev_rdy` is 0 and returns to 1 in the cycle `dev_rdy` is 1. The commit happens at that clock edge. With no strobe active, `wait_n` is 1.
- R10: When a bus write to the data register and a local load (`dev_load`) fall on the same edge, the bus value is stored. A local load alone stores `dev_din`.
- R11: `online` equals `online_sw` as sampled at the previous clock edge.
- R12: With `rd_n` and `wr_n` both 0, the access is a read and neither register is written.
- R13: Each strobe commits once. Holding a strobe after its commit neither re-latches nor re-pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bus_rst | input | 1 | Synchronous reset from the channel, active high |
| online_sw | input | 1 | Operator online switch |
| online | output | 1 | Registered online flag to the host |
| sel | input | 1 | Register select: 0 data, 1 command/status |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dq_in | input | 12 | Word from the host |
| dq_out | output | 12 | Word to the host, zero-padded |
| dq_oe | output | 1 | Drive enable for dq_out |
| int_n | output | 1 | Interrupt request, active low |
| ack_n | input | 1 | Interrupt acknowledge, active low |
| wait_n | output | 1 | Transfer stretch, active low |
| dev_req | input | 1 | Device logic attention request pulse |
| dev_rdy | input | 1 | Device logic ready to finish a transfer |
| dev_load | input | 1 | Local load of the data register |
| dev_din | input | NAT_W | Local value for the data register |
| dev_status | input | NAT_W | Status word returned on command reads |
| dev_data | output | NAT_W | Current data register |
| dev_cmd | output | NAT_W | Last command word written |
| cmd_pulse | output | 1 | One-clock pulse after a command write |
| data_taken | output | 1 | One-clock pulse after a data read |

## Verification
Two pairs of functions can land on the same clock edge.
- **Bus write against local load.** The bench raises `dev_load` with a different value at the exact negative edge where it raises `dev_rdy` during a held data write. The commit and the local load then share one rising edge, and `dev_data` is judged against the bus value.
- **Request against acknowledge.** The bench drives `dev_req` high and `ack_n` low in the same cycle, and checks that `int_n` stays high.

Random transfers with random stall lengths also place a collision on about one in eight transfers. Every commit is checked against a bench-side register model.

// File: rtl/chan_ep_pkg.sv
package chan_ep_pkg;

  // transfer sequencer states
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_HOLD = 2'd1,
    XS_DONE = 2'd2
  } xfer_state_e;

  // register select encoding on the sel line
  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_CTRL = 1'b1;

endpackage

// File: rtl/chan_xfer_fsm.sv
module chan_xfer_fsm
  import chan_ep_pkg::*;
#(
  parameter bit STRETCH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_n,
  input  logic wr_n,
  input  logic rdy_i,
  output logic commit_rd,
  output logic commit_wr,
  output logic wait_n
);

  xfer_state_e state_q, state_d;
  logic        strobe;
  logic        rd_act;
  logic        commit;
  logic        hold_req;

  assign rd_act = !rd_n;
  assign strobe = !rd_n || !wr_n;

  generate
    if (STRETCH) begin : g_stretch
      assign commit   = (state_q == XS_HOLD) && strobe && rdy_i;
      assign hold_req = strobe &&
                        ((state_q == XS_IDLE) ||
                         ((state_q == XS_HOLD) && !rdy_i));
    end else begin : g_direct
      logic unused_rdy;
      assign unused_rdy = rdy_i;
      assign commit     = (state_q == XS_IDLE) && strobe;
      assign hold_req   = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE: if (strobe) state_d = STRETCH ? XS_HOLD : XS_DONE;
      XS_HOLD: begin
        if (!strobe)    state_d = XS_IDLE;
        else if (rdy_i) state_d = XS_DONE;
      end
      XS_DONE: if (!strobe) state_d = XS_IDLE;
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= XS_IDLE;
    else     state_q <= state_d;
  end

  // a read strobe takes precedence when both are low
  assign commit_rd = commit && rd_act;
  assign commit_wr = commit && !rd_act;
  assign wait_n    = !hold_req;

endmodule

// File: rtl/chan_regfile.sv
module chan_regfile
  import chan_ep_pkg::*;
#(
  parameter int BUS_W = 12,
  parameter int NAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             rd_n,
  input  logic [BUS_W-1:0] dq_in,
  input  logic             commit_rd,
  input  logic             commit_wr,
  input  logic             loc_load,
  input  logic [NAT_W-1:0] loc_din,
  input  logic [NAT_W-1:0] loc_status,
  output logic [BUS_W-1:0] dq_out,
  output logic             dq_oe,
  output logic [NAT_W-1:0] data_q,
  output logic [NAT_W-1:0] cmd_q,
  output logic             cmd_pulse,
  output logic             data_taken
);

  // zero-extend a native word onto the bus
  function automatic logic [BUS_W-1:0] widen(input logic [NAT_W-1:0] v);
    logic [BUS_W-1:0] t;
    t = '0;
    t[NAT_W-1:0] = v;
    return t;
  endfunction

  // keep only the native bits of a bus word
  function automatic logic [NAT_W-1:0] narrow(input logic [BUS_W-1:0] v);
    return v[NAT_W-1:0];
  endfunction

  logic unused_hi;
  assign unused_hi = ^dq_in;

  logic wr_data, wr_ctrl;
  assign wr_data = commit_wr && (sel == SEL_DATA);
  assign wr_ctrl = commit_wr && (sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (wr_data) begin
      data_q <= narrow(dq_in);
    end else if (loc_load) begin
      data_q <= loc_din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= '0;
      cmd_pulse  <= 1'b0;
      data_taken <= 1'b0;
    end else begin
      if (wr_ctrl) cmd_q <= narrow(dq_in);
      cmd_pulse  <= wr_ctrl;
      data_taken <= commit_rd && (sel == SEL_DATA);
    end
  end

  always_comb begin
    dq_oe  = !rd_n;
    dq_out = '0;
    if (!rd_n) dq_out = (sel == SEL_CTRL) ? widen(loc_status) : widen(data_q);
  end

endmodule

// File: rtl/chan_irq.sv
module chan_irq (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic ack_n,
  output logic pend_q,
  output logic int_n
);

  always_ff @(posedge clk) begin
    if (rst)         pend_q <= 1'b0;
    else if (!ack_n) pend_q <= 1'b0;
    else if (req_i)  pend_q <= 1'b1;
  end

  assign int_n = !pend_q;

endmodule

// File: rtl/chan_endpoint.sv
module chan_endpoint #(
  parameter int BUS_W   = 12,
  parameter int NAT_W   = 8,
  parameter bit STRETCH = 1'b1
) (
  input  logic             clk,
  input  logic             bus_rst,
  input  logic             online_sw,
  output logic             online,
  input  logic             sel,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [BUS_W-1:0] dq_in,
  output logic [BUS_W-1:0] dq_out,
  output logic             dq_oe,
  output logic             int_n,
  input  logic             ack_n,
  output logic             wait_n,
  input  logic             dev_req,
  input  logic             dev_rdy,
  input  logic             dev_load,
  input  logic [NAT_W-1:0] dev_din,
  input  logic [NAT_W-1:0] dev_status,
  output logic [NAT_W-1:0] dev_data,
  output logic [NAT_W-1:0] dev_cmd,
  output logic             cmd_pulse,
  output logic             data_taken
);

  // named internal events, observed by the bound checker
  logic xfer_commit_rd;
  logic xfer_commit_wr;
  logic irq_pend;

  chan_xfer_fsm #(.STRETCH(STRETCH)) u_xfer (
    .clk       (clk),
    .rst       (bus_rst),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rdy_i     (dev_rdy),
    .commit_rd (xfer_commit_rd),
    .commit_wr (xfer_commit_wr),
    .wait_n    (wait_n)
  );

  chan_regfile #(.BUS_W(BUS_W), .NAT_W(NAT_W)) u_regs (
    .clk        (clk),
    .rst        (bus_rst),
    .sel        (sel),
    .rd_n       (rd_n),
    .dq_in      (dq_in),
    .commit_rd  (xfer_commit_rd),
    .commit_wr  (xfer_commit_wr),
    .loc_load   (dev_load),
    .loc_din    (dev_din),
    .loc_status (dev_status),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .data_q     (dev_data),
    .cmd_q      (dev_cmd),
    .cmd_pulse  (cmd_pulse),
    .data_taken (data_taken)
  );

  chan_irq u_irq (
    .clk    (clk),
    .rst    (bus_rst),
    .req_i  (dev_req),
    .ack_n  (ack_n),
    .pend_q (irq_pend),
    .int_n  (int_n)
  );

  always_ff @(posedge clk) begin
    if (bus_rst) online <= 1'b0;
    else         online <= online_sw;
  end

endmodule

// File: rtl/chan_endpoint_chk.sv
module chan_endpoint_chk #(
  parameter int BUS_W = 12,
  parameter int NAT_W = 8
) (
  input logic             clk,
  input logic             bus_rst,
  input logic             online_sw,
  input logic             online,
  input logic             sel,
  input logic             rd_n,
  input logic             wr_n,
  input logic [BUS_W-1:0] dq_in,
  input logic [BUS_W-1:0] dq_out,
  input logic             dq_oe,
  input logic             int_n,
  input logic             ack_n,
  input logic             wait_n,
  input logic             dev_rdy,
  input logic             dev_load,
  input logic [NAT_W-1:0] dev_data,
  input logic [NAT_W-1:0] dev_cmd,
  input logic             cmd_pulse,
  input logic             data_taken,
  input logic             xfer_commit_rd,
  input logic             xfer_commit_wr,
  input logic             irq_pend
);

  p_read_drive_r2: assert property (@(posedge clk) disable iff (bus_rst)
    !rd_n |-> dq_oe);

  p_bus_float_r3: assert property (@(posedge clk) disable iff (bus_rst)
    rd_n |-> (!dq_oe && dq_out == '0));

  p_pad_r4: assert property (@(posedge clk) disable iff (bus_rst)
    (dq_out >> NAT_W) == '0);

  p_data_load_r5: assert property (@(posedge clk) disable iff (bus_rst)
    (xfer_commit_wr && !sel) |=> dev_data == $past(dq_in[NAT_W-1:0]));

  p_ctrl_load_r6: assert property (@(posedge clk) disable iff (bus_rst)
    (xfer_commit_wr && sel) |=> (cmd_pulse && dev_cmd == $past(dq_in[NAT_W-1:0])));

  p_taken_r7: assert property (@(posedge clk) disable iff (bus_rst)
    (xfer_commit_rd && !sel) |=> data_taken);

  p_int_hold_r8: assert property (@(posedge clk) disable iff (bus_rst)
    (!int_n && ack_n) |=> !int_n);

  p_int_ack_r8: assert property (@(posedge clk) disable iff (bus_rst)
    !ack_n |=> (int_n && !irq_pend));

  p_wait_idle_r9: assert property (@(posedge clk) disable iff (bus_rst)
    (rd_n && wr_n) |-> wait_n);

  p_commit_unstalled_r9: assert property (@(posedge clk) disable iff (bus_rst)
    (xfer_commit_rd || xfer_commit_wr) |-> (wait_n && dev_rdy));

  p_online_r11: assert property (@(posedge clk) disable iff (bus_rst)
    !$past(bus_rst) |-> online == $past(online_sw));

  p_dual_strobe_r12: assert property (@(posedge clk) disable iff (bus_rst)
    (!rd_n && !wr_n && !dev_load) |=> ($stable(dev_data) && !cmd_pulse));

  p_one_pulse_r13: assert property (@(posedge clk) disable iff (bus_rst)
    cmd_pulse |=> !cmd_pulse);

  p_one_taken_r13: assert property (@(posedge clk) disable iff (bus_rst)
    data_taken |=> !data_taken);

endmodule

bind chan_endpoint chan_endpoint_chk #(.BUS_W(BUS_W), .NAT_W(NAT_W)) u_chk (
  .clk            (clk),
  .bus_rst        (bus_rst),
  .online_sw      (online_sw),
  .online         (online),
  .sel            (sel),
  .rd_n           (rd_n),
  .wr_n           (wr_n),
  .dq_in          (dq_in),
  .dq_out         (dq_out),
  .dq_oe          (dq_oe),
  .int_n          (int_n),
  .ack_n          (ack_n),
  .wait_n         (wait_n),
  .dev_rdy        (dev_rdy),
  .dev_load       (dev_load),
  .dev_data       (dev_data),
  .dev_cmd        (dev_cmd),
  .cmd_pulse      (cmd_pulse),
  .data_taken     (data_taken),
  .xfer_commit_rd (xfer_commit_rd),
  .xfer_commit_wr (xfer_commit_wr),
  .irq_pend       (irq_pend)
);

// File: tb/test_chan_endpoint.sv
`timescale 1ns/1ps
module test_chan_endpoint;

  localparam int BW = 12;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          bus_rst = 1'b1;
  logic          online_sw = 1'b0;
  logic          online;
  logic          sel = 1'b0;
  logic          rd_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [BW-1:0] dq_in = '0;
  logic [BW-1:0] dq_out;
  logic          dq_oe;
  logic          int_n;
  logic          ack_n = 1'b1;
  logic          wait_n;
  logic          dev_req = 1'b0;
  logic          dev_rdy = 1'b0;
  logic          dev_load = 1'b0;
  logic [NW-1:0] dev_din = '0;
  logic [NW-1:0] dev_status = '0;
  logic [NW-1:0] dev_data;
  logic [NW-1:0] dev_cmd;
  logic          cmd_pulse;
  logic          data_taken;

  always #2 clk = !clk;

  chan_endpoint #(.BUS_W(BW), .NAT_W(NW), .STRETCH(1'b1)) i_chan_endpoint (
    .clk(clk), .bus_rst(bus_rst), .online_sw(online_sw), .online(online),
    .sel(sel), .rd_n(rd_n), .wr_n(wr_n), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .int_n(int_n), .ack_n(ack_n), .wait_n(wait_n),
    .dev_req(dev_req), .dev_rdy(dev_rdy), .dev_load(dev_load),
    .dev_din(dev_din), .dev_status(dev_status), .dev_data(dev_data),
    .dev_cmd(dev_cmd), .cmd_pulse(cmd_pulse), .data_taken(data_taken)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [NW-1:0] exp_data = '0;
  logic [NW-1:0] exp_cmd = '0;

  // bench view of the padding rule: mask a bus word down to its native bits
  function automatic logic [BW-1:0] pad_of(input logic [NW-1:0] v);
    return BW'(v) & ((BW'(1) << NW) - BW'(1));
  endfunction

  function automatic logic [NW-1:0] low_of(input logic [BW-1:0] v);
    return NW'(v % (1 << NW));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    bus_rst = 1'b1;
    repeat (3) @(negedge clk);
    bus_rst = 1'b0;
    exp_data = '0;
    exp_cmd = '0;
    #1;
    chk("R1 data cleared", 32'(dev_data), 0);
    chk("R1 cmd cleared", 32'(dev_cmd), 0);
    chk("R1 int released", 32'(int_n), 1);
    chk("R1 wait released", 32'(wait_n), 1);
    chk("R1 bus off", 32'(dq_oe), 0);
    chk("R1 pulses low", 32'({cmd_pulse, data_taken}), 0);
    chk("R1 online low", 32'(online), 0);
  endtask

  task automatic do_xfer(input bit is_rd, input bit is_wr, input bit s,
                         input logic [BW-1:0] v, input int dly,
                         input bit collide, input logic [NW-1:0] ld_val);
    logic [BW-1:0] rd_exp;
    bit eff_wr;
    eff_wr = is_wr && !is_rd;
    @(negedge clk);
    sel = s; dq_in = v; rd_n = !is_rd; wr_n = !is_wr; dev_rdy = 1'b0;
    #1;
    chk("R9 wait on detect", 32'(wait_n), 0);
    rd_exp = s ? pad_of(dev_status) : pad_of(exp_data);
    if (is_rd) begin
      chk("R2 read enable", 32'(dq_oe), 1);
      chk("R2 read word", 32'(dq_out), 32'(rd_exp));
      chk("R4 upper zero", 32'(dq_out[BW-1:NW]), 0);
    end
    for (int k = 0; k < dly; k++) begin
      @(negedge clk); #1;
      chk("R9 wait held", 32'(wait_n), 0);
    end
    @(negedge clk);
    dev_rdy = 1'b1;
    if (collide) begin dev_load = 1'b1; dev_din = ld_val; end
    #1;
    chk("R9 wait release", 32'(wait_n), 1);
    if (is_rd) chk("R2 read at release", 32'(dq_out), 32'(rd_exp));
    if (eff_wr && !s) exp_data = low_of(v);
    else if (collide) exp_data = ld_val;
    if (eff_wr && s) exp_cmd = low_of(v);
    @(negedge clk);
    dev_load = 1'b0;
    #1;
    chk(collide ? "R5/R10 data after commit" : "R5/R12 data after commit",
        32'(dev_data), 32'(exp_data));
    chk("R6 cmd word", 32'(dev_cmd), 32'(exp_cmd));
    chk("R6 cmd pulse", 32'(cmd_pulse), 32'(eff_wr && s));
    chk("R7 data taken", 32'(data_taken), 32'(is_rd && !s));
    @(negedge clk); #1;
    chk("R13 no repeat pulse", 32'({cmd_pulse, data_taken}), 0);
    chk("R13 data stable", 32'(dev_data), 32'(exp_data));
    rd_n = 1'b1; wr_n = 1'b1; dev_rdy = 1'b0;
    #1;
    chk("R3 bus off", 32'(dq_oe), 0);
    chk("R3 bus zero", 32'(dq_out), 0);
    chk("R9 wait idle", 32'(wait_n), 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();

    // directed: padding and truncation
    do_xfer(0, 1, 0, 12'hFFF, 0, 0, '0);
    do_xfer(1, 0, 0, 12'h000, 2, 0, '0);
    dev_status = 8'hA5;
    do_xfer(1, 0, 1, 12'h000, 1, 0, '0);
    do_xfer(0, 1, 1, 12'h9C3, 3, 0, '0);

    // directed: bus write and local load on the same edge
    do_xfer(0, 1, 0, 12'h412, 1, 1, 8'h77);
    // local load alone
    @(negedge clk); dev_load = 1'b1; dev_din = 8'h3C;
    @(negedge clk); dev_load = 1'b0; exp_data = 8'h3C; #1;
    chk("R10 local load", 32'(dev_data), 32'h3C);

    // directed: both strobes low counts as a read
    do_xfer(1, 1, 0, 12'hABC, 0, 0, '0);

    // interrupt handshake
    @(negedge clk); dev_req = 1'b1;
    @(negedge clk); dev_req = 1'b0; #1;
    chk("R8 int asserted", 32'(int_n), 0);
    repeat (4) begin @(negedge clk); #1; chk("R8 int held", 32'(int_n), 0); end
    @(negedge clk); ack_n = 1'b0;
    @(negedge clk); ack_n = 1'b1; #1;
    chk("R8 int released", 32'(int_n), 1);
    @(negedge clk); dev_req = 1'b1; ack_n = 1'b0;
    @(negedge clk); dev_req = 1'b0; ack_n = 1'b1; #1;
    chk("R8 ack beats req", 32'(int_n), 1);

    // online flag
    @(negedge clk); online_sw = 1'b1; #1;
    chk("R11 online lag", 32'(online), 0);
    @(negedge clk); #1;
    chk("R11 online follows", 32'(online), 1);

    // pending interrupt and registers cleared by reset
    @(negedge clk); dev_req = 1'b1;
    @(negedge clk); dev_req = 1'b0;
    do_reset();

    // random transfers
    for (int i = 0; i < 150; i++) begin
      logic [2:0] kind;
      kind = 3'($urandom_range(0, 7));
      dev_status = NW'($urandom);
      do_xfer(kind[0] || (kind == 3'd6), !kind[0], kind[1],
              BW'($urandom), int'($urandom_range(0, 3)),
              ($urandom_range(0, 7) == 0), NW'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule